// File: doc/BRIEF.md
# Bus line monitor with idle detector

This block watches the four pins of a two-wire management bus: the clock line, the data line, a control line and an alert line. Each pin is asynchronous to the system clock. The block passes each pin through a two-stage synchronizer and presents the result as a level output. It keeps two sticky event flags. One records an edge on the control line, and a configuration input chooses whether that is the rising or the falling edge. The other records falling edges on the alert line only.

A bus-idle output goes high once the synchronized clock and data lines have both stayed high for a set number of system clock cycles. That number is the parameter `IDLE_CYCLES`. At 125 MHz, the default of 6250 is 50 microseconds. A low on either line clears the idle output and restarts the count.

Firmware clears each event flag by pulsing its clear input for one cycle. If an event arrives in the same cycle as the clear, the event wins. An interrupt request is high whenever either event flag is set. The bus protocol engine and any analog glitch filtering sit outside this block.

Top module: `bus_line_watch`

## Requirements
- R1: `scl_lvl`, `sda_lvl`, `ctl_lvl` and `alr_lvl` show their pin as sampled two rising clock edges earlier (pin sampled at edge k appears after edge k+1).
- R2: `ctl_edge_flag` is set one cycle after `ctl_lvl` changes in the selected direction. `ctl_rise_sel`=1 selects low-to-high and `ctl_rise_sel`=0 selects high-to-low. A change in the other direction sets nothing.
- R3: `alr_edge_flag` is set one cycle after `alr_lvl` goes from 1 to 0. A 0-to-1 change on `alr_lvl` never sets it.
- R4: A set edge flag stays set until its clear input is high at a clock edge. If a new event for that flag is detected at the same edge, the flag stays set.
- R5: `bus_idle` goes high after the edge at which `scl_lvl` and `sda_lvl` have both been 1 for `IDLE_CYCLES` consecutive cycles. It stays high while both remain 1.
- R6: If either `scl_lvl` or `sda_lvl` is 0 before an edge, `bus_idle` is 0 after that edge and the idle count restarts from zero.
- R7: `irq` is 1 in exactly those cycles in which `ctl_edge_flag` or `alr_edge_flag` is 1.
- R8: While `rst_n` is 0, all level outputs read 1 and both flags and `bus_idle` read 0. Filling the synchronizer after reset never sets an edge flag: no event is detected before the fourth edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_pin | input | 1 | Bus clock pin, asynchronous |
| sda_pin | input | 1 | Bus data pin, asynchronous |
| ctl_pin | input | 1 | Control pin, asynchronous |
| alr_pin | input | 1 | Alert pin, asynchronous |
| ctl_rise_sel | input | 1 | 1: control flag on rising edge, 0: on falling edge |
| clr_ctl_edge | input | 1 | Write-one-to-clear strobe for the control edge flag |
| clr_alr_edge | input | 1 | Write-one-to-clear strobe for the alert edge flag |
| scl_lvl | output | 1 | Synchronized clock line level |
| sda_lvl | output | 1 | Synchronized data line level |
| ctl_lvl | output | 1 | Synchronized control line level |
| alr_lvl | output | 1 | Synchronized alert line level |
| ctl_edge_flag | output | 1 | Sticky control edge flag |
| alr_edge_flag | output | 1 | Sticky alert falling-edge flag |
| bus_idle | output | 1 | Clock and data both high for the idle timeout |
| irq | output | 1 | Interrupt request, OR of the edge flags |

## Verification
The bench drives a clear strobe in exactly the cycle in which a control event is detected. A design that lets the clear win would drop that event. It flips `ctl_rise_sel` between edges and raises the alert line. A design with the polarity inverted, or one that flags every alert edge, would raise flags it should not. Short low pulses on the data line land just before the idle timeout expires. An off-by-one counter would raise `bus_idle` a cycle early or late, and a counter that is not restarted would raise it too soon. The bench also holds the control line low through reset. A design that detects an edge while its synchronizer fills after reset would flag that spurious edge.

// File: rtl/bus_line_watch.sv
module bus_line_watch #(
  parameter int IDLE_CYCLES = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_pin,
  input  logic sda_pin,
  input  logic ctl_pin,
  input  logic alr_pin,
  input  logic ctl_rise_sel,
  input  logic clr_ctl_edge,
  input  logic clr_alr_edge,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic ctl_lvl,
  output logic alr_lvl,
  output logic ctl_edge_flag,
  output logic alr_edge_flag,
  output logic bus_idle,
  output logic irq
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

  logic [3:0] meta, sync, prev;
  logic [1:0] warm;
  logic [CW-1:0] run;
  logic live, ctl_hit, alr_hit, lines_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 4'hF;
      sync <= 4'hF;
      prev <= 4'hF;
      warm <= 2'd0;
    end else begin
      meta <= {alr_pin, ctl_pin, sda_pin, scl_pin};
      sync <= meta;
      prev <= sync;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  assign live    = (warm == 2'd3);
  assign ctl_hit = live && (ctl_rise_sel ? (sync[2] && !prev[2]) : (!sync[2] && prev[2]));
  assign alr_hit = live && !sync[3] && prev[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_edge_flag <= 1'b0;
      alr_edge_flag <= 1'b0;
    end else begin
      ctl_edge_flag <= ctl_hit || (ctl_edge_flag && !clr_ctl_edge);
      alr_edge_flag <= alr_hit || (alr_edge_flag && !clr_alr_edge);
    end
  end

  assign lines_high = sync[0] && sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= '0;
      bus_idle <= 1'b0;
    end else if (!lines_high) begin
      run      <= '0;
      bus_idle <= 1'b0;
    end else if (run == LAST) begin
      bus_idle <= 1'b1;
    end else begin
      run <= run + 1'b1;
    end
  end

  assign scl_lvl = sync[0];
  assign sda_lvl = sync[1];
  assign ctl_lvl = sync[2];
  assign alr_lvl = sync[3];
  assign irq     = ctl_edge_flag || alr_edge_flag;
endmodule

module bus_line_watch_chk (
  input logic clk,
  input logic rst_n,
  input logic ctl_rise_sel,
  input logic clr_ctl_edge,
  input logic clr_alr_edge,
  input logic scl_lvl,
  input logic sda_lvl,
  input logic ctl_lvl,
  input logic alr_lvl,
  input logic ctl_edge_flag,
  input logic alr_edge_flag,
  input logic bus_idle,
  input logic irq
);
  p_ctl_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_edge_flag) |-> ($past(ctl_rise_sel) ? ($past(ctl_lvl) && !$past(ctl_lvl, 2))
                                                  : (!$past(ctl_lvl) && $past(ctl_lvl, 2))));

  p_alert_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alr_edge_flag) |-> (!$past(alr_lvl) && $past(alr_lvl, 2)));

  p_ctl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_edge_flag && !clr_ctl_edge) |=> ctl_edge_flag);

  p_alr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alr_edge_flag && !clr_alr_edge) |=> alr_edge_flag);

  p_alr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_alr_edge && alr_lvl) |=> !alr_edge_flag);

  p_idle_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_lvl && sda_lvl) |=> !bus_idle);

  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctl_edge_flag) || $rose(alr_edge_flag)) |-> irq);
endmodule

bind bus_line_watch bus_line_watch_chk u_chk (.*);

// File: tb/bus_line_watch_test.sv
module bus_line_watch_test;
  localparam int IDLE = 24;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_pin = 1'b1, sda_pin = 1'b1, ctl_pin = 1'b0, alr_pin = 1'b1;
  logic ctl_rise_sel = 1'b1, clr_ctl_edge = 1'b0, clr_alr_edge = 1'b0;
  logic scl_lvl, sda_lvl, ctl_lvl, alr_lvl, ctl_edge_flag, alr_edge_flag, bus_idle, irq;

  bus_line_watch #(.IDLE_CYCLES(IDLE)) uut (.*);

  int errors = 0, checks = 0;
  bit done = 1'b0;

  logic [3:0] hist[$];
  int   nedge = 0, run = 0;
  logic [3:0] m_lvl = 4'hF, m_prv = 4'hF;
  bit   m_cf = 0, m_af = 0, m_idle = 0, ev_c, ev_a;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      nedge = 0; run = 0; m_lvl = 4'hF; m_prv = 4'hF;
      m_cf = 0; m_af = 0; m_idle = 0;
    end else begin
      ev_c = (nedge >= 3) && (ctl_rise_sel ? (m_lvl[2] && !m_prv[2]) : (!m_lvl[2] && m_prv[2]));
      ev_a = (nedge >= 3) && !m_lvl[3] && m_prv[3];
      m_cf = ev_c || (m_cf && !clr_ctl_edge);
      m_af = ev_a || (m_af && !clr_alr_edge);
      if (m_lvl[0] && m_lvl[1]) begin
        if (run < IDLE + 4) run++;
      end else run = 0;
      m_idle = (run >= IDLE);
      m_prv = m_lvl;
      hist.push_back({alr_pin, ctl_pin, sda_pin, scl_pin});
      if (hist.size() > 2) void'(hist.pop_front());
      if (hist.size() == 2) m_lvl = hist[0];
      nedge++;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk(rst_n ? "R1 scl level" : "R8 reset scl", scl_lvl, m_lvl[0]);
      chk(rst_n ? "R1 sda level" : "R8 reset sda", sda_lvl, m_lvl[1]);
      chk(rst_n ? "R1 ctl level" : "R8 reset ctl", ctl_lvl, m_lvl[2]);
      chk(rst_n ? "R1 alr level" : "R8 reset alr", alr_lvl, m_lvl[3]);
      chk(rst_n ? "R2/R4 ctl flag" : "R8 reset ctl flag", ctl_edge_flag, m_cf);
      chk(rst_n ? "R3/R4 alr flag" : "R8 reset alr flag", alr_edge_flag, m_af);
      chk(rst_n ? "R5/R6 bus idle" : "R8 reset idle", bus_idle, m_idle);
      chk("R7 irq", irq, m_cf || m_af);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(6);
    chk("R8 no flag from fill", ctl_edge_flag, 1'b0);
    step(IDLE);
    chk("R5 idle reached", bus_idle, 1'b1);
    sda_pin = 1'b0; step(1); sda_pin = 1'b1;
    step(4);
    chk("R6 idle cleared", bus_idle, 1'b0);
    step(IDLE - 2);
    sda_pin = 1'b0; step(1); sda_pin = 1'b1;
    step(IDLE + 4);
    chk("R5 idle after restart", bus_idle, 1'b1);
    ctl_rise_sel = 1'b1; ctl_pin = 1'b1; step(4);
    chk("R2 rising flagged", ctl_edge_flag, 1'b1);
    chk("R7 irq on flag", irq, 1'b1);
    clr_ctl_edge = 1'b1; step(1); clr_ctl_edge = 1'b0;
    ctl_pin = 1'b0; step(4);
    chk("R2 falling ignored when rise selected", ctl_edge_flag, 1'b0);
    ctl_rise_sel = 1'b0; ctl_pin = 1'b1; step(4);
    chk("R2 rising ignored when fall selected", ctl_edge_flag, 1'b0);
    ctl_pin = 1'b0; step(4);
    chk("R2 falling flagged", ctl_edge_flag, 1'b1);
    ctl_pin = 1'b1; step(4);
    ctl_rise_sel = 1'b1; ctl_pin = 1'b0; step(4);
    ctl_pin = 1'b1; step(2);
    clr_ctl_edge = 1'b1; step(1); clr_ctl_edge = 1'b0;
    step(1);
    chk("R4 event beats clear", ctl_edge_flag, 1'b1);
    clr_ctl_edge = 1'b1; step(1); clr_ctl_edge = 1'b0;
    step(1);
    chk("R4 clear works", ctl_edge_flag, 1'b0);
    alr_pin = 1'b0; step(4);
    chk("R3 alert fall flagged", alr_edge_flag, 1'b1);
    clr_alr_edge = 1'b1; step(1); clr_alr_edge = 1'b0;
    alr_pin = 1'b1; step(4);
    chk("R3 alert rise ignored", alr_edge_flag, 1'b0);
    chk("R7 irq low", irq, 1'b0);
    for (int i = 0; i < 600; i++) begin
      scl_pin = ($urandom_range(0, 9) != 0);
      sda_pin = ($urandom_range(0, 9) != 0);
      ctl_pin = $urandom_range(0, 1);
      alr_pin = $urandom_range(0, 1);
      ctl_rise_sel = ($urandom_range(0, 7) != 0) ? ctl_rise_sel : ~ctl_rise_sel;
      clr_ctl_edge = ($urandom_range(0, 5) == 0);
      clr_alr_edge = ($urandom_range(0, 5) == 0);
      step((i % 50 < 40) ? 1 : IDLE / 2);
    end
    scl_pin = 1'b1; sda_pin = 1'b1; clr_ctl_edge = 1'b0; clr_alr_edge = 1'b0;
    step(IDLE + 4);
    chk("R5 idle at end", bus_idle, 1'b1);
    summary();
  end
endmodule